// File: doc/BRIEF.md
# LED Driver Command Serializer

This block drives the three-wire command stream of a chain of constant-current LED drivers: a shift clock, a serial data line and a latch line. The driver tells one command from another only by how many shift-clock rising edges occur while the latch line is high, not by any opcode bits. The block therefore shifts a data word out, most significant bit first, and lifts the latch so that it covers exactly the required number of final rising edges.

A host presents four function-control words and one grayscale word on parallel inputs. It then asks for one operation with a 3-bit code: a function-control write unlock, a write of one of the four control registers, a grayscale latch, or a frame sync. A typical start-up issues the unlock, then control words one to four, then grayscale words, then the frame sync. The third control word carries the scan-line count, for example 32 lines.

The shift clock runs at the system clock divided by `2*HALF_DIV`. Data and latch change only while the shift clock is low. Every command begins with one full shift-clock period of quiet line, so the latch stays low for at least that long between commands.

Top module: `led_cmd_serializer`

## Requirements
- R1: After reset, `sclk`, `sin`, `lat` and `busy` are all low, and they stay low until a command is accepted.
- R2: Op code 0 (write unlock) produces exactly 15 `sclk` rising edges, with `lat` high at every one of them and `sin` low throughout.
- R3: Op codes 1, 2, 3 and 4 (control words one to four) shift `WORD_W` bits of `fc1_word` to `fc4_word`, MSB first. `lat` is high at exactly the last 5, 7, 9 and 11 rising edges of the shift, respectively.
- R4: Op code 5 (grayscale latch) shifts `WORD_W` bits of `gs_word`, MSB first, with `lat` high only at the final rising edge.
- R5: Op code 6 (frame sync) produces exactly 3 `sclk` rising edges, with `lat` high at all of them and `sin` low.
- R6: `sin` and `lat` change only while `sclk` is low, so each is stable at every rising edge.
- R7: Between the fall of `lat` and its next rise, `lat` stays low for at least one full `sclk` period (`2*HALF_DIV` clock cycles).
- R8: `busy` rises on the cycle after a valid request is accepted and falls on the same edge at which `lat` falls. A request made while `busy` is high is ignored and causes no extra edges.
- R9: Op code 7 is undefined. It is ignored: `busy` stays low and no `sclk` edge appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Request strobe, sampled when `busy` is low |
| cmd_op | input | 3 | Operation code (0 unlock, 1-4 control word, 5 grayscale, 6 sync, 7 undefined) |
| fc1_word | input | WORD_W | Control word one |
| fc2_word | input | WORD_W | Control word two |
| fc3_word | input | WORD_W | Control word three (scan-line count) |
| fc4_word | input | WORD_W | Control word four |
| gs_word | input | WORD_W | Grayscale word |
| busy | output | 1 | High from acceptance until the latch falls |
| sclk | output | 1 | Serial shift clock |
| sin | output | 1 | Serial data, MSB first |
| lat | output | 1 | Latch line; its high window selects the command |

## Verification
A wrong remaining-edge count or latch-window length shows up within a single command. It appears as a latch window that starts one edge early or late, or as a total edge count other than 15, 3 or `WORD_W`. The driver would then take the command for a different one. A shift-register fault shows up as a wrong captured word on the first data command that uses the affected bit. A stuck state or busy flag shows up within one command time: `busy` either never falls, or falls while `lat` is still high, or a second request sneaks in mid-shift and stretches the edge count.

// File: rtl/led_cmd_serializer.sv
module led_cmd_serializer #(
  parameter int WORD_W   = 48,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [WORD_W-1:0] fc1_word,
  input  logic [WORD_W-1:0] fc2_word,
  input  logic [WORD_W-1:0] fc3_word,
  input  logic [WORD_W-1:0] fc4_word,
  input  logic [WORD_W-1:0] gs_word,
  output logic              busy,
  output logic              sclk,
  output logic              sin,
  output logic              lat
);
  localparam int CW = $clog2(WORD_W + 1);
  localparam int DW = $clog2(2 * HALF_DIV + 1);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_LOW, S_HIGH} state_t;

  state_t            state_q;
  logic [DW-1:0]     div_q;
  logic [CW-1:0]     edges_q, win_q;
  logic [WORD_W-1:0] shreg_q;

  logic [WORD_W-1:0] ld_word;
  logic [CW-1:0]     ld_edges, ld_win;

  always_comb begin
    ld_word  = '0;
    ld_edges = CW'(WORD_W);
    ld_win   = CW'(1);
    case (cmd_op)
      3'd0: begin ld_edges = CW'(15); ld_win = CW'(15); end
      3'd1: begin ld_word = fc1_word; ld_win = CW'(5);  end
      3'd2: begin ld_word = fc2_word; ld_win = CW'(7);  end
      3'd3: begin ld_word = fc3_word; ld_win = CW'(9);  end
      3'd4: begin ld_word = fc4_word; ld_win = CW'(11); end
      3'd5: begin ld_word = gs_word;  ld_win = CW'(1);  end
      3'd6: begin ld_edges = CW'(3); ld_win = CW'(3); end
      default: ;
    endcase
  end

  wire accept   = cmd_valid && (cmd_op != 3'd7) && (state_q == S_IDLE);
  wire div_done = (state_q == S_LEAD) ? (div_q == DW'(2 * HALF_DIV - 1))
                                      : (div_q == DW'(HALF_DIV - 1));
  wire [CW-1:0] edges_dec = edges_q - CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      div_q   <= '0;
      edges_q <= '0;
      win_q   <= '0;
      shreg_q <= '0;
      busy    <= 1'b0;
      sclk    <= 1'b0;
      sin     <= 1'b0;
      lat     <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (accept) begin
          shreg_q <= ld_word;
          edges_q <= ld_edges;
          win_q   <= ld_win;
          div_q   <= '0;
          busy    <= 1'b1;
          state_q <= S_LEAD;
        end
        S_LEAD: if (div_done) begin
          div_q   <= '0;
          sin     <= shreg_q[WORD_W-1];
          shreg_q <= shreg_q << 1;
          lat     <= (edges_q <= win_q);
          state_q <= S_LOW;
        end else div_q <= div_q + DW'(1);
        S_LOW: if (div_done) begin
          div_q   <= '0;
          sclk    <= 1'b1;
          state_q <= S_HIGH;
        end else div_q <= div_q + DW'(1);
        S_HIGH: if (div_done) begin
          div_q <= '0;
          sclk  <= 1'b0;
          if (edges_q == CW'(1)) begin
            edges_q <= '0;
            busy    <= 1'b0;
            lat     <= 1'b0;
            sin     <= 1'b0;
            state_q <= S_IDLE;
          end else begin
            edges_q <= edges_dec;
            sin     <= shreg_q[WORD_W-1];
            shreg_q <= shreg_q << 1;
            lat     <= (edges_dec <= win_q);
            state_q <= S_LOW;
          end
        end else div_q <= div_q + DW'(1);
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/led_cmd_serializer_chk.sv
module led_cmd_serializer_chk #(
  parameter int HALF_DIV = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       busy,
  input logic       sclk,
  input logic       sin,
  input logic       lat
);
  localparam int GAP = 2 * HALF_DIV;
  localparam int GW  = $clog2(GAP + 1);

  logic [GW-1:0] low_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) low_cnt <= GW'(GAP);
    else if (lat) low_cnt <= '0;
    else if (low_cnt < GW'(GAP)) low_cnt <= low_cnt + GW'(1);
  end

  a_r6_sin_changes_sclk_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sin) |-> !sclk);
  a_r6_lat_changes_sclk_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lat) |-> !sclk);
  a_r7_lat_low_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lat) |-> low_cnt >= GW'(GAP));
  a_r8_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op != 3'd7) |=> busy);
  a_r8_lat_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
    lat |-> busy);
  a_r8_busy_ends_with_lat: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $fell(lat));
  a_r9_bad_op_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 3'd7) |=> !busy);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && !lat));
endmodule

bind led_cmd_serializer led_cmd_serializer_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .busy(busy), .sclk(sclk), .sin(sin), .lat(lat)
);

// File: tb/test_led_cmd_serializer.sv
module test_led_cmd_serializer;
  localparam int CLK_P  = 10;
  localparam int W      = 48;
  localparam int HALF   = 2;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [W-1:0] fc1 = '0, fc2 = '0, fc3 = '0, fc4 = '0, gs = '0;
  logic busy, sclk, sin, lat;

  led_cmd_serializer #(.WORD_W(W), .HALF_DIV(HALF)) i_led_cmd_serializer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .fc1_word(fc1), .fc2_word(fc2), .fc3_word(fc3), .fc4_word(fc4),
    .gs_word(gs), .busy(busy), .sclk(sclk), .sin(sin), .lat(lat));

  always #(CLK_P/2) clk = ~clk;

  int n_run = 0, n_fail = 0;
  int n_edges = 0, n_lat = 0, first_lat = 0, last_lat = 0;
  bit sin_any = 0;
  int bad_change = 0;
  int cyc = 0;
  logic [W-1:0] cap = '0;

  always @(posedge clk) cyc++;

  always @(posedge sclk) begin
    n_edges++;
    cap = {cap[W-2:0], sin};
    if (sin) sin_any = 1;
    if (lat) begin
      if (n_lat == 0) first_lat = n_edges;
      n_lat++;
      last_lat = n_edges;
    end
  end

  always @(sin or lat) if (rst_n && sclk) bad_change++;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    n_edges = 0; n_lat = 0; first_lat = 0; last_lat = 0; sin_any = 0; cap = '0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic issue(input logic [2:0] op);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run_cmd(input logic [2:0] op);
    clear_mon();
    issue(op);
    wait_idle();
  endtask

  function automatic bit tail_ok(input int win);
    return (n_lat == win) && (last_lat == n_edges) && (first_lat == n_edges - win + 1);
  endfunction

  task automatic t_reset();
    check(!sclk && !sin && !lat && !busy, "R1 reset state", {busy, sclk, sin, lat}, 0);
  endtask

  task automatic t_unlock();
    run_cmd(3'd0);
    check(n_edges == 15, "R2 unlock edges", n_edges, 15);
    check(tail_ok(15) && !sin_any, "R2 unlock latch/data", n_lat, 15);
  endtask

  task automatic t_fc(input logic [2:0] op, input int win, input logic [W-1:0] word);
    run_cmd(op);
    check(n_edges == W, "R3 control edges", n_edges, W);
    check(cap == word, "R3 control data MSB first", cap, word);
    check(tail_ok(win), "R3 control latch window", n_lat, win);
  endtask

  task automatic t_gs(input logic [W-1:0] word);
    gs = word;
    run_cmd(3'd5);
    check(n_edges == W && cap == word, "R4 grayscale data", cap, word);
    check(tail_ok(1), "R4 grayscale latch last edge", n_lat, 1);
  endtask

  task automatic t_vsync();
    run_cmd(3'd6);
    check(n_edges == 3 && tail_ok(3) && !sin_any, "R5 sync edges/latch", n_edges, 3);
  endtask

  task automatic t_busy_ignore();
    clear_mon();
    issue(3'd1);
    check(busy == 1'b1, "R8 busy after accept", busy, 1);
    repeat (20) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd5;
    repeat (6) @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
    check(!lat && !busy, "R8 busy falls with latch", {busy, lat}, 0);
    check(n_edges == W && tail_ok(5), "R8 busy request ignored", n_edges, W);
    repeat (40) @(negedge clk);
    check(n_edges == W && !busy, "R8 no late command", n_edges, W);
  endtask

  task automatic t_bad_op();
    clear_mon();
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd7;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    check(!busy, "R9 undefined op busy", busy, 0);
    repeat (40) @(negedge clk);
    check(n_edges == 0 && !lat, "R9 undefined op edges", n_edges, 0);
  endtask

  task automatic t_gap();
    int t0;
    run_cmd(3'd6);
    t0 = cyc;
    clear_mon();
    issue(3'd6);
    @(posedge lat);
    check(cyc - t0 >= 2 * HALF, "R7 latch low gap", cyc - t0, 2 * HALF);
    wait_idle();
    check(n_edges == 3 && tail_ok(3), "R5 back-to-back sync", n_edges, 3);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    fc1 = 48'hA5C3_0F1E_8001;
    fc2 = 48'h1234_5678_9ABC;
    fc3 = 48'h0000_0000_001F;
    fc4 = 48'hFFFF_0000_FFFF;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(!sclk && !lat && !busy, "R1 idle after reset", {busy, sclk, lat}, 0);
    t_unlock();
    t_fc(3'd1, 5, fc1);
    t_fc(3'd2, 7, fc2);
    t_fc(3'd3, 9, fc3);
    t_fc(3'd4, 11, fc4);
    t_gs(48'h8000_0000_0001);
    t_gs(48'h6DB6_DB6D_B6DB);
    t_vsync();
    t_busy_ignore();
    t_bad_op();
    t_gap();
    check(bad_change == 0, "R6 data/latch stable while sclk high", bad_change, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule